// File: doc/BRIEF.md
# Reloading Down-Counter Timer

A countdown timer that sits on a simple register bus. Software sets a start value and a control word. While the timer is enabled, the counter drops by one on each pulse of the chosen tick enable. There are two tick inputs, one for a fast time base and one for a slow one. The step that would take the counter below zero is an underflow. On underflow the block raises a level interrupt and sets a new count. In periodic mode the new count is the stored start value. In free-running mode it is the all-ones value.

The interrupt stays high until software writes to the acknowledge register. The data of that write does not matter. The counter width is a parameter, and the same RTL serves a 16-bit build and a 32-bit build. Clock division, bus bridging and interrupt routing stay outside the block.

Top module: `down_timer`

## Requirements
- R1: After reset the start value, the count, the control word and the interrupt are all zero.
- R2: Word offsets within the bus window (decoded from `addr_i[3:2]`):
  - 0x0 is the start value, read/write.
  - 0x4 is the live count, read only.
  - 0x8 is the control word, read/write.
  - 0xC is the interrupt acknowledge, which reads 0.

  Control bits other than 7, 6 and 3 read back as 0.
- R3: While control bit 7 is 0, the count does not change under any tick. Writing 0 to the control word stops the timer.
- R4: Control bit 3 set selects `tick_fast_i`, and bit 3 clear selects `tick_slow_i`. Pulses on the unselected tick have no effect.
- R5: When enabled, each pulse of the selected tick lowers a nonzero count by exactly one. The new value shows after the clock edge that sampled the pulse.
- R6: With control bit 6 set, a tick taken at count 0 loads the count with the stored start value.
- R7: With control bit 6 clear, a tick taken at count 0 wraps the count to all ones of the counter width.
- R8: An underflow sets `irq_o` at the next clock edge. `irq_o` then stays high until it is acknowledged.
- R9: A write to offset 0xC with any data drops `irq_o`. If an underflow happens in the same cycle, the underflow wins and `irq_o` stays high.
- R10: A start-value write while the timer is disabled also sets the count. The same write while the timer is enabled leaves the running count untouched.
- R11: Start-value bits above the counter width are dropped, and reads of the start value and the count are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address within the register window |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| tick_fast_i | input | 1 | Fast time-base tick enable |
| tick_slow_i | input | 1 | Slow time-base tick enable |
| irq_o | output | 1 | Level interrupt, set on underflow |

## Verification
Two functions can land in the same cycle: the acknowledge write that clears the interrupt, and an underflow that sets it.

A directed sequence counts a periodic timer down to zero. It then issues the acknowledge write in the very cycle that the selected tick arrives. The interrupt must still be high and the count must hold the reloaded value.

The random phase mixes acknowledge writes with short start values and dense ticks, so the collision recurs many times. Each cycle a bench model that gives the underflow priority judges the outcome. Start-value writes that meet a tick on an enabled timer get the same treatment: the running count must ignore the write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // word index, addr[3:2]
  localparam logic [1:0] REG_LOAD  = 2'd0;
  localparam logic [1:0] REG_VALUE = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_CLEAR = 2'd3;

  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_we_o,
  output logic              clr_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [1:0]        widx;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] load_ext, cnt_ext, ctrl_rd;

  assign widx      = addr_i[3:2];
  assign load_we_o = we_i && (widx == REG_LOAD);
  assign clr_we_o  = we_i && (widx == REG_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (we_i && widx == REG_CTRL) begin
        ctrl_q.en       <= wdata_i[BIT_EN];
        ctrl_q.periodic <= wdata_i[BIT_PER];
        ctrl_q.fast     <= wdata_i[BIT_FAST];
      end
      if (load_we_o) load_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

  if (PAD_W > 0) begin : g_pad
    assign load_ext = {{PAD_W{1'b0}}, load_q};
    assign cnt_ext  = {{PAD_W{1'b0}}, count_i};
  end else begin : g_full
    assign load_ext = load_q;
    assign cnt_ext  = count_i;
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[BIT_EN]   = ctrl_q.en;
    ctrl_rd[BIT_PER]  = ctrl_q.periodic;
    ctrl_rd[BIT_FAST] = ctrl_q.fast;
    case (widx)
      REG_LOAD:  rdata_o = load_ext;
      REG_VALUE: rdata_o = cnt_ext;
      REG_CTRL:  rdata_o = ctrl_rd;
      default:   rdata_o = '0;
    endcase
  end

  assert_ctrl_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == REG_CTRL) |-> (rdata_o[2:0] == 3'b0 && rdata_o[5:4] == 2'b0 &&
                            (rdata_o >> 8) == '0));
  assert_clear_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == REG_CLEAR) |-> rdata_o == '0);
  assert_ctrl_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && widx == REG_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  output logic [CNT_W-1:0] count_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] count_q;
  logic             tick_sel, step, at_zero;

  assign tick_sel = ctrl_i.fast ? tick_fast_i : tick_slow_i;
  assign step     = ctrl_i.en && tick_sel;
  assign at_zero  = (count_q == '0);
  assign uf_o     = step && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (load_we_i && !ctrl_i.en) begin
      count_q <= load_data_i;
    end else if (step) begin
      if (at_zero) count_q <= ctrl_i.periodic ? load_i : '1;
      else         count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  assert_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !load_we_i) |=> $stable(count_q));
  assert_other_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en && !(ctrl_i.fast ? tick_fast_i : tick_slow_i)) |=> $stable(count_q));
  assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_q != '0) |=> count_q == CNT_W'($past(count_q) - 1'b1));
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && ctrl_i.periodic) |=> count_q == $past(load_i));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !ctrl_i.periodic) |=> count_q == '1);
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  // underflow outranks the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (uf_i)  irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> irq_o);
  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uf_i) |=> !irq_o);
  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !uf_i) |=> !irq_o);
endmodule

// File: rtl/down_timer.sv
module down_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load, count;
  logic             load_we, clr_we, uf;

  timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .count_i   (count),
    .ctrl_o    (ctrl),
    .load_o    (load),
    .load_we_o (load_we),
    .clr_we_o  (clr_we),
    .rdata_o
  );

  timer_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni,
    .ctrl_i      (ctrl),
    .load_i      (load),
    .load_we_i   (load_we),
    .load_data_i (wdata_i[CNT_W-1:0]),
    .tick_fast_i, .tick_slow_i,
    .count_o     (count),
    .uf_o        (uf)
  );

  timer_irq i_irq (
    .clk_i, .rst_ni,
    .uf_i  (uf),
    .clr_i (clr_we),
    .irq_o
  );
endmodule

// File: tb/test_down_timer.sv
module test_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, tf = 1'b0, ts = 1'b0;
  logic [31:0] rd [2];
  logic        irq [2];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  down_timer i_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rd[0]), .tick_fast_i(tf), .tick_slow_i(ts), .irq_o(irq[0]));

  down_timer #(.CNT_W(16)) i_down_timer_n16 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rd[1]), .tick_fast_i(tf), .tick_slow_i(ts), .irq_o(irq[1]));

  // reference model
  logic [31:0] mask [2] = '{32'hFFFF_FFFF, 32'h0000_FFFF};
  logic [31:0] m_load [2], m_cnt [2];
  logic        m_en, m_per, m_fast;
  logic        m_irq [2];

  always @(posedge clk or negedge rst_n) begin : model
    logic step, uf, nen, nper, nfast;
    logic [31:0] ncnt, nload;
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_fast = 0;
      for (int k = 0; k < 2; k++) begin
        m_load[k] = 0; m_cnt[k] = 0; m_irq[k] = 0;
      end
    end else begin
      nen = m_en; nper = m_per; nfast = m_fast;
      if (we && addr[3:2] == 2'd2) begin
        nen = wdata[7]; nper = wdata[6]; nfast = wdata[3];
      end
      for (int k = 0; k < 2; k++) begin
        step  = m_en && (m_fast ? tf : ts);
        uf    = step && m_cnt[k] == 0;
        ncnt  = m_cnt[k];
        nload = m_load[k];
        if (we && addr[3:2] == 2'd0) nload = wdata & mask[k];
        if (we && addr[3:2] == 2'd0 && !m_en) ncnt = wdata & mask[k];
        else if (step) ncnt = uf ? (m_per ? m_load[k] : mask[k]) : m_cnt[k] - 1;
        if (uf) m_irq[k] = 1;
        else if (we && addr[3:2] == 2'd3) m_irq[k] = 0;
        m_cnt[k] = ncnt; m_load[k] = nload;
      end
      m_en = nen; m_per = nper; m_fast = nfast;
    end
  end

  function automatic logic [31:0] exp_rd(int k, logic [3:0] a);
    case (a[3:2])
      2'd0:    return m_load[k];
      2'd1:    return m_cnt[k];
      2'd2:    return {24'b0, m_en, m_per, 2'b0, m_fast, 3'b0};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, result visible at next negedge
  task automatic cyc(logic w, logic [3:0] a, logic [31:0] d, logic f, logic s);
    we = w; addr = a; wdata = d; tf = f; ts = s;
    @(negedge clk);
    we = 0; tf = 0; ts = 0;
  endtask

  task automatic rd_both(string tag, logic [3:0] a, logic [31:0] exp);
    addr = a; #1;
    for (int k = 0; k < 2; k++) chk(tag, rd[k], exp & mask[k]);
  endtask

  task automatic irq_both(string tag, logic exp);
    for (int k = 0; k < 2; k++) chk(tag, {31'b0, irq[k]}, {31'b0, exp});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_both("R1 load", 4'h0, 0);
    rd_both("R1 value", 4'h4, 0);
    rd_both("R1 ctrl", 4'h8, 0);
    irq_both("R1 irq", 0);
    // R2 map, R10 load while off, R11 truncation
    cyc(1, 4'h0, 32'h1234_5678, 0, 0);
    rd_both("R11 load read", 4'h0, 32'h1234_5678);
    rd_both("R10 load copies count", 4'h4, 32'h1234_5678);
    cyc(1, 4'h8, 32'hFFFF_FF37, 0, 0);
    rd_both("R2 reserved ctrl bits", 4'h8, 0);
    cyc(1, 4'h8, 32'h0000_0048, 0, 0);
    rd_both("R2 ctrl readback", 4'h8, 32'h48);
    rd_both("R2 clear reads 0", 4'hC, 0);
    // R3 disabled holds
    repeat (5) cyc(0, 4'h0, 0, 1, 1);
    rd_both("R3 disabled hold", 4'h4, 32'h1234_5678);
    // R4/R5/R6/R8
    cyc(1, 4'h0, 32'd3, 0, 0);
    cyc(1, 4'h8, 32'hC8, 0, 0);
    repeat (4) cyc(0, 4'h0, 0, 0, 1);
    rd_both("R4 slow tick ignored", 4'h4, 3);
    cyc(0, 4'h4, 0, 1, 0);
    rd_both("R5 decrement", 4'h4, 2);
    cyc(0, 4'h4, 0, 1, 0);
    cyc(0, 4'h4, 0, 1, 0);
    rd_both("R5 reach zero", 4'h4, 0);
    irq_both("R8 no irq before underflow", 0);
    cyc(0, 4'h4, 0, 1, 0);
    rd_both("R6 reload", 4'h4, 3);
    irq_both("R8 irq set", 1);
    cyc(0, 4'h4, 0, 1, 0);
    cyc(0, 4'h4, 0, 1, 0);
    irq_both("R8 irq held", 1);
    rd_both("R5 count after reload", 4'h4, 1);
    // R9 clear and collision
    cyc(1, 4'hC, 32'h0, 0, 0);
    irq_both("R9 clear", 0);
    cyc(0, 4'h4, 0, 1, 0);
    rd_both("R9 setup zero", 4'h4, 0);
    cyc(1, 4'hC, 32'hDEAD_BEEF, 1, 0);
    irq_both("R9 underflow beats clear", 1);
    rd_both("R9 reload on collision", 4'h4, 3);
    // R10 load while enabled
    cyc(1, 4'h0, 32'd9, 0, 0);
    rd_both("R10 running count kept", 4'h4, 3);
    rd_both("R10 load updated", 4'h0, 9);
    // R7 free-run wrap
    cyc(1, 4'h8, 32'h80, 0, 0);
    repeat (3) cyc(0, 4'h4, 0, 0, 1);
    rd_both("R7 at zero", 4'h4, 0);
    cyc(0, 4'h4, 0, 0, 1);
    rd_both("R7 wrap all ones", 4'h4, 32'hFFFF_FFFF);
    // R3 control 0 stops
    cyc(1, 4'h8, 32'h0, 0, 0);
    repeat (4) cyc(0, 4'h4, 0, 1, 1);
    rd_both("R3 stopped by zero ctrl", 4'h4, 32'hFFFF_FFFF);
    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      logic w;
      a = {$urandom_range(3), 2'b00};
      w = ($urandom_range(3) == 0);
      d = $urandom;
      if (a == 4'h0 && $urandom_range(3) != 0) d = $urandom_range(7);
      if (a == 4'h8 && $urandom_range(3) != 0) d = d | 32'h80;
      cyc(w, a, d, $urandom_range(1) == 1, $urandom_range(2) != 0);
      #1;
      for (int k = 0; k < 2; k++) begin
        chk("R5 R6 R7 R9 R10 random read", rd[k], exp_rd(k, a));
        chk("R8 R9 random irq", {31'b0, irq[k]}, {31'b0, m_irq[k]});
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule